// File: doc/BRIEF.md
# SM3 Message Word Expander

This block turns one 512-bit message block into the stream of expanded words that an SM3 compression core uses over its 64 rounds. When a start pulse arrives with the block, it splits the block into sixteen 32-bit words. From the next cycle on it presents, once per round, the word W[j] together with the paired word W'[j] = W[j] ^ W[j+4]. Padding, the chaining value and the round arithmetic are left to the surrounding design.

Recent words are held in a sixteen-deep window of registers. On every round advance, the oldest word leaves the window and a new word computed by the SM3 recurrence enters it. The window always starts at the current round, so the word four positions ahead is already present and the paired word is a plain XOR of two window slots. A stall input holds the stream still, so a slower consumer can pace it. A byte-order input, sampled with the start pulse, selects whether each 32-bit word is read as it stands (big-endian) or with its four bytes reversed.

Top module: `sm3_wexp`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is 0 and `round_o` is 0 until a start pulse is accepted.
- R2: A start pulse while `valid_o` is 0 is accepted at the clock edge. In the next cycle `valid_o` is 1, `round_o` is 0 and `w_o` holds message word 0, which is taken from bits 511:480 of `block_i`.
- R3: With `swap_i` at 0 when start is accepted, message word i is `block_i[511-32*i -: 32]` taken as it stands. With `swap_i` at 1, the four bytes inside each such word are reversed: byte 0 (bits 7:0) becomes bits 31:24.
- R4: For rounds 0 to 15, `w_o` equals message words 0 to 15 in order.
- R5: For j >= 16, W[j] = P1(W[j-16] ^ W[j-9] ^ (W[j-3] <<< 15)) ^ (W[j-13] <<< 7) ^ W[j-6], where P1(x) = x ^ (x <<< 15) ^ (x <<< 23).
- R6: In every round j from 0 to 63, `wp_o` equals W[j] ^ W[j+4]. This includes rounds 60 to 63, which need W[64] to W[67].
- R7: While `valid_o` is 1 and `stall_i` is 0, `round_o` advances by one at each clock edge. After round 63 is presented in a cycle without stall, `valid_o` drops to 0 at the next edge.
- R8: While `valid_o` is 1 and `stall_i` is 1, `round_o`, `w_o`, `wp_o` and `valid_o` keep their values at the next edge.
- R9: A start pulse, and any change of `block_i` or `swap_i`, while `valid_o` is 1 has no effect on the word stream in progress.
- R10: After a block completes, a new start pulse begins a fresh stream from round 0 using the new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the block and begin a stream (accepted only while idle) |
| swap_i | input | 1 | 1: reverse the bytes within each 32-bit word at load |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| stall_i | input | 1 | Hold the current round and its outputs |
| valid_o | output | 1 | The round outputs are meaningful |
| round_o | output | 6 | Index of the round being presented |
| w_o | output | 32 | Expanded word W[round] |
| wp_o | output | 32 | Paired word W[round] ^ W[round+4] |

## Verification
The bench builds the block with its default parameters: 64 rounds, a sixteen-word window and a lead of four words. With these values the full schedule is reachable, including the tail rounds 60 to 63 whose paired words need W[64] to W[67]. This tail is the one place where the run-ahead could go wrong. The word values come from the standard padded "abc" block and one other block, both in straight and byte-swapped loading. The streams are run with no stall and with a periodic stall pattern, and a start pulse is issued in the middle of a stream.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;

    localparam int WORD_W   = 32;
    localparam int BLOCK_W  = 512;
    localparam int N_WORDS  = BLOCK_W / WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // P1 permutation; the 23-bit turn reuses the 15-bit one plus 8 more
    function automatic word_t perm1(input word_t x);
        word_t r15;
        r15 = rotl(x, 15);
        return x ^ r15 ^ rotl(r15, 8);
    endfunction

endpackage

// File: rtl/sm3x_unpack.sv
module sm3x_unpack
    import sm3x_pkg::*;
#(
    parameter int NW = N_WORDS
) (
    input  logic [NW*WORD_W-1:0]     blk,
    input  logic                     swap,
    output logic [NW-1:0][WORD_W-1:0] words
);
    localparam int NB = WORD_W / 8;

    for (genvar i = 0; i < NW; i++) begin : g_word
        logic [WORD_W-1:0] raw;
        logic [WORD_W-1:0] rev;
        assign raw = blk[NW*WORD_W-1-WORD_W*i -: WORD_W];
        for (genvar b = 0; b < NB; b++) begin : g_byte
            assign rev[WORD_W-1-8*b -: 8] = raw[8*b +: 8];
        end
        assign words[i] = swap ? rev : raw;
    end

endmodule

// File: rtl/sm3x_recur.sv
module sm3x_recur
    import sm3x_pkg::*;
(
    input  word_t w_m16,
    input  word_t w_m13,
    input  word_t w_m9,
    input  word_t w_m6,
    input  word_t w_m3,
    output word_t w_new
);
    word_t mix;

    always_comb begin
        mix   = w_m16 ^ w_m9 ^ rotl(w_m3, 15);
        w_new = perm1(mix) ^ rotl(w_m13, 7) ^ w_m6;
    end

endmodule

// File: rtl/sm3_wexp.sv
module sm3_wexp
    import sm3x_pkg::*;
#(
    parameter int ROUNDS = 64,
    parameter int WIN    = 16,
    parameter int LEAD   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      swap_i,
    input  logic [BLOCK_W-1:0]        block_i,
    input  logic                      stall_i,
    output logic                      valid_o,
    output logic [$clog2(ROUNDS)-1:0] round_o,
    output logic [WORD_W-1:0]         w_o,
    output logic [WORD_W-1:0]         wp_o
);
    localparam int RW = $clog2(ROUNDS);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    typedef struct packed {
        logic                      run;
        logic [RW-1:0]             round;
        logic [WIN-1:0][WORD_W-1:0] win;
    } state_t;

    state_t st_d, st_q;

    logic [WIN-1:0][WORD_W-1:0] load_words;
    word_t                      fresh;

    sm3x_unpack #(.NW(WIN)) u_unpack (
        .blk   (block_i),
        .swap  (swap_i),
        .words (load_words)
    );

    // Window slot k holds W[round+k]; the new word is W[round+16]
    sm3x_recur u_recur (
        .w_m16 (st_q.win[0]),
        .w_m13 (st_q.win[3]),
        .w_m9  (st_q.win[7]),
        .w_m6  (st_q.win[10]),
        .w_m3  (st_q.win[13]),
        .w_new (fresh)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.run   = 1'b1;
                st_d.round = '0;
                st_d.win   = load_words;
            end
        end else if (!stall_i) begin
            if (st_q.round == LAST) begin
                st_d.run = 1'b0;
            end else begin
                st_d.round = st_q.round + 1'b1;
                st_d.win   = {fresh, st_q.win[WIN-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.run;
    assign round_o = st_q.round;
    assign w_o     = st_q.win[0];
    assign wp_o    = st_q.win[0] ^ st_q.win[LEAD];

    // R2: idle start begins at round 0
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && start_i |=> valid_o && round_o == '0);

    // R1: no start keeps the block idle
    a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && !start_i |=> !valid_o);

    // R7: one round per unstalled cycle
    a_r7_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !stall_i && round_o != LAST |=>
            valid_o && round_o == RW'($past(round_o) + 1'b1));

    // R7: stream ends after the last round
    a_r7_last_drop: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !stall_i && round_o == LAST |=> !valid_o);

    // R8: stall freezes every output
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && stall_i |=> valid_o && $stable(round_o) && $stable(w_o) && $stable(wp_o));

    // R5: window slides by one word on advance
    a_r5_window_slide: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !stall_i && round_o != LAST |=> w_o == $past(st_q.win[1]));

endmodule

// File: tb/sm3_wexp_bench.sv
module sm3_wexp_bench;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         start_i = 0;
    logic         swap_i = 0;
    logic [511:0] block_i = '0;
    logic         stall_i = 0;
    logic         valid_o;
    logic [5:0]   round_o;
    logic [31:0]  w_o, wp_o;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] ref_w [0:67];

    always #2 clk = ~clk;

    sm3_wexp u_sm3_wexp (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .swap_i(swap_i),
        .block_i(block_i), .stall_i(stall_i), .valid_o(valid_o),
        .round_o(round_o), .w_o(w_o), .wp_o(wp_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    // expected words from the message words alone (R4, R5)
    task automatic build_ref(input logic [511:0] msg);
        for (int i = 0; i < 16; i++) ref_w[i] = msg[511-32*i -: 32];
        for (int j = 16; j < 68; j++) begin
            logic [31:0] x;
            x = ref_w[j-16] ^ ref_w[j-9] ^ rl(ref_w[j-3], 15);
            ref_w[j] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(ref_w[j-13], 7) ^ ref_w[j-6];
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] swapped(input logic [511:0] msg);
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[511-32*i -: 32] = bswap(msg[511-32*i -: 32]);
        return r;
    endfunction

    // one full stream; msg is the logical block, sw picks the load order
    task automatic run_block(input logic [511:0] msg, input bit sw, input bit stall_on, input bit busy_start);
        int exp_r = 0;
        int cyc = 0;
        bit fired = 0;
        bit was_stall = 0;
        logic [31:0] pw = '0, ppw = '0;
        logic [5:0] pr = '0;
        build_ref(msg);
        @(negedge clk);
        block_i = sw ? swapped(msg) : msg;
        swap_i  = sw;
        start_i = 1;
        stall_i = 0;
        while (exp_r < 64 && cyc < 1000) begin
            @(negedge clk);
            start_i = 0;
            chk(valid_o == 1, "R2/R7 valid", {31'b0, valid_o}, 32'd1);
            chk(round_o == 6'(exp_r), "R7 round", {26'b0, round_o}, exp_r);
            if (exp_r < 16)
                chk(w_o == ref_w[exp_r], sw ? "R3 swap word" : "R4 msg word", w_o, ref_w[exp_r]);
            else
                chk(w_o == ref_w[exp_r], "R5 expanded word", w_o, ref_w[exp_r]);
            chk(wp_o == (ref_w[exp_r] ^ ref_w[exp_r+4]), "R6 paired word", wp_o, ref_w[exp_r] ^ ref_w[exp_r+4]);
            if (was_stall) begin
                chk(w_o == pw, "R8 hold w", w_o, pw);
                chk(wp_o == ppw, "R8 hold wp", wp_o, ppw);
                chk(round_o == pr, "R8 hold round", {26'b0, round_o}, {26'b0, pr});
            end
            pw = w_o; ppw = wp_o; pr = round_o;
            if (busy_start && exp_r == 10 && !fired) begin
                // R9: start and new data mid-stream must be ignored
                start_i = 1;
                block_i = ~block_i;
                swap_i  = ~swap_i;
                fired   = 1;
            end
            stall_i   = stall_on && (cyc % 3 == 1);
            was_stall = stall_i;
            if (!stall_i) exp_r++;
            cyc++;
        end
        @(negedge clk);
        start_i = 0;
        chk(valid_o == 0, "R7 end of stream", {31'b0, valid_o}, 32'd0);
    endtask

    task automatic t_reset;
        chk(valid_o == 0, "R1 reset valid", {31'b0, valid_o}, 0);
        chk(round_o == 0, "R1 reset round", {26'b0, round_o}, 0);
        @(negedge clk); rst_n = 1;
        repeat (3) @(negedge clk);
        chk(valid_o == 0, "R1 idle valid", {31'b0, valid_o}, 0);
        chk(round_o == 0, "R1 idle round", {26'b0, round_o}, 0);
    endtask

    logic [511:0] abc_blk;
    logic [511:0] alt_blk;

    initial begin
        abc_blk = '0;
        abc_blk[511:480] = 32'h6162_6380;
        abc_blk[31:0]    = 32'h0000_0018;
        for (int i = 0; i < 16; i++) alt_blk[511-32*i -: 32] = 32'h0102_0304 * (i + 7) ^ 32'hA5C3_0F96;
        t_reset();
        run_block(abc_blk, 0, 0, 0);   // R2 R4 R5 R6 R7
        run_block(abc_blk, 1, 0, 0);   // R3 byte-swapped load
        run_block(alt_blk, 0, 1, 0);   // R8 stalls, R10 restart with new block
        run_block(alt_blk, 1, 1, 1);   // R9 busy start ignored
        run_block(abc_blk, 0, 0, 1);   // R10 back to the first block
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule